// File: doc/BRIEF.md
# Layered OSD Pixel Compositor

This block merges the per-dot outputs of an on-screen display pipeline into one digital color for the current pixel. Each clock it receives the state of six stacked layers (a whole-screen fill color, a screen pattern dot, a row background, a cell background, a glyph dot and a sprite dot), decides which layer is visible, applies raised or sunken bevel shading to the two background layers, and converts the winning 4-bit color index into a 6-bit color through a 16-entry programmable palette.

Alongside the color it produces two flags for downstream video mixing: a display flag that marks dots where on-screen content covers the picture, and a halftone flag that marks dots where only a background fill is showing. Each flag has its own enable and polarity control. Font fetch, raster timing and analog encoding sit upstream or downstream of this block; the palette is loaded through a single-cycle write port.

Top module: `osd_pixel_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `color_out` = 0, `disp_out` = 0 and `half_out` = 0, whatever the layer inputs are.
- R2: Outputs are registered: the layer inputs present at a rising edge determine `color_out`, `disp_out` and `half_out` from that edge until the next one, and input changes between edges do not alter them.
- R3: When `spr_dot` is 1 the output color is the palette entry of `spr_color`, over every other layer.
- R4: With `blink_en` = 1 and `blink_phase` = 0 the glyph dot is hidden and the layer below it shows; with `blink_phase` = 1 or `blink_en` = 0 the glyph dot shows normally.
- R5: Below the sprite, the priority from top to bottom is glyph dot (`fg_dot`), cell background, row background, screen pattern dot (`pat_dot`), screen fill color (`scr_en`).
- R6: When no layer is visible (including `scr_en` = 0), `color_out` is 0; the screen fill shows the palette entry of `scr_color` only when `scr_en` = 1.
- R7: A background mode value of 0 makes that background transparent; 1 fills it with its own color regardless of edge inputs.
- R8: Mode 3 (raised) paints dots with the top/left edge input set in `hl_color` and dots with the bottom/right edge input set in `sh_color`; when both edge inputs are set, the top/left treatment wins; other dots take the background's own color.
- R9: Mode 2 (sunken) swaps the two: top/left edges take `sh_color`, bottom/right edges take `hl_color`, top/left again winning when both are set.
- R10: `color_out` is the 6-bit palette entry addressed by the winning 4-bit index; a write with `pal_we` = 1 updates entry `pal_addr` to `pal_data` for pixels presented in later cycles.
- R11: The display flag is 1 when the winning layer is anything other than the screen fill color (and something is visible), else 0.
- R12: The halftone flag is 1 only when the winning layer is the cell background or the row background.
- R13: With the enable at 0 the flag pin is 0; with enable 1 and polarity 1 the pin equals the flag; with enable 1 and polarity 0 the pin is the inverted flag. This applies separately to `disp_out` (`disp_en`, `disp_pol`) and `half_out` (`half_en`, `half_pol`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| scr_en | input | 1 | Screen fill color layer on |
| scr_color | input | 4 | Screen fill color index |
| pat_dot | input | 1 | Screen pattern dot active |
| pat_color | input | 4 | Screen pattern dot color index |
| row_mode | input | 2 | Row background mode (0 off, 1 fill, 2 sunken, 3 raised) |
| row_color | input | 4 | Row background color index |
| row_edge_tl | input | 1 | Dot lies on the row's top or left edge |
| row_edge_br | input | 1 | Dot lies on the row's bottom or right edge |
| cell_mode | input | 2 | Cell background mode (0 off, 1 fill, 2 sunken, 3 raised) |
| cell_color | input | 4 | Cell background color index |
| cell_edge_tl | input | 1 | Dot lies on the cell's top or left edge |
| cell_edge_br | input | 1 | Dot lies on the cell's bottom or right edge |
| fg_dot | input | 1 | Glyph dot active |
| fg_color | input | 4 | Glyph color index |
| blink_en | input | 1 | Blink enabled for this cell |
| blink_phase | input | 1 | Blink phase, 1 = visible half |
| spr_dot | input | 1 | Sprite dot active |
| spr_color | input | 4 | Sprite dot color index |
| hl_color | input | 4 | Screen-wide bevel highlight index |
| sh_color | input | 4 | Screen-wide bevel shadow index |
| disp_en | input | 1 | Display flag pin enable |
| disp_pol | input | 1 | Display flag polarity, 1 = active high |
| half_en | input | 1 | Halftone flag pin enable |
| half_pol | input | 1 | Halftone flag polarity, 1 = active high |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 4 | Palette entry to write |
| pal_data | input | 6 | Palette entry value |
| color_out | output | 6 | Resolved pixel color |
| disp_out | output | 1 | Display period pin |
| half_out | output | 1 | Halftone period pin |

## Verification
The assertions assume that the layer inputs are stable across each rising edge and that the edge inputs are only meaningful in a shaded mode, so a dot flagged on both edges is legal and resolved by rule rather than excluded. They also assume the palette is not written and read at the same entry in the same cycle; the bench keeps to this by loading and rewriting palette entries only in cycles where the affected color is not being checked, and by changing all inputs one nanosecond after an edge. The stimulus builds layer stacks one layer at a time so each priority step and each bevel corner is seen in isolation.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  typedef enum logic [1:0] {
    BG_OFF    = 2'd0,
    BG_FILL   = 2'd1,
    BG_SUNKEN = 2'd2,
    BG_RAISED = 2'd3
  } bg_mode_e;

  typedef enum logic [2:0] {
    LY_NONE   = 3'd0,
    LY_SCREEN = 3'd1,
    LY_PAT    = 3'd2,
    LY_ROW    = 3'd3,
    LY_CELL   = 3'd4,
    LY_GLYPH  = 3'd5,
    LY_SPRITE = 3'd6
  } layer_e;

endpackage

// File: rtl/osd_bevel_shade.sv
module osd_bevel_shade
  import osd_mix_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  bg_mode_e           mode,
  input  logic [IDX_W-1:0]   base,
  input  logic               edge_tl,
  input  logic               edge_br,
  input  logic [IDX_W-1:0]   light,
  input  logic [IDX_W-1:0]   dark,
  output logic               vis,
  output logic [IDX_W-1:0]   color
);

  always_comb begin
    vis   = (mode != BG_OFF);
    color = base;
    case (mode)
      BG_RAISED: begin
        if (edge_tl)      color = light;
        else if (edge_br) color = dark;
      end
      BG_SUNKEN: begin
        if (edge_tl)      color = dark;
        else if (edge_br) color = light;
      end
      default: color = base;
    endcase
  end

endmodule

// File: rtl/osd_layer_arbiter.sv
module osd_layer_arbiter
  import osd_mix_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic               scr_vis,
  input  logic [IDX_W-1:0]   scr_idx,
  input  logic               pat_vis,
  input  logic [IDX_W-1:0]   pat_idx,
  input  logic               row_vis,
  input  logic [IDX_W-1:0]   row_idx,
  input  logic               cell_vis,
  input  logic [IDX_W-1:0]   cell_idx,
  input  logic               glyph_vis,
  input  logic [IDX_W-1:0]   glyph_idx,
  input  logic               spr_vis,
  input  logic [IDX_W-1:0]   spr_idx,
  output layer_e             winner,
  output logic [IDX_W-1:0]   win_idx
);

  always_comb begin
    winner  = LY_NONE;
    win_idx = '0;
    if (spr_vis) begin
      winner  = LY_SPRITE;
      win_idx = spr_idx;
    end else if (glyph_vis) begin
      winner  = LY_GLYPH;
      win_idx = glyph_idx;
    end else if (cell_vis) begin
      winner  = LY_CELL;
      win_idx = cell_idx;
    end else if (row_vis) begin
      winner  = LY_ROW;
      win_idx = row_idx;
    end else if (pat_vis) begin
      winner  = LY_PAT;
      win_idx = pat_idx;
    end else if (scr_vis) begin
      winner  = LY_SCREEN;
      win_idx = scr_idx;
    end
  end

endmodule

// File: rtl/osd_palette_ram.sv
module osd_palette_ram #(
  parameter int IDX_W = 4,
  parameter int OUT_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [OUT_W-1:0]   wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [OUT_W-1:0]   rdata
);

  logic [OUT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/osd_pixel_mixer.sv
module osd_pixel_mixer
  import osd_mix_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OUT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scr_en,
  input  logic [IDX_W-1:0]   scr_color,
  input  logic               pat_dot,
  input  logic [IDX_W-1:0]   pat_color,
  input  logic [1:0]         row_mode,
  input  logic [IDX_W-1:0]   row_color,
  input  logic               row_edge_tl,
  input  logic               row_edge_br,
  input  logic [1:0]         cell_mode,
  input  logic [IDX_W-1:0]   cell_color,
  input  logic               cell_edge_tl,
  input  logic               cell_edge_br,
  input  logic               fg_dot,
  input  logic [IDX_W-1:0]   fg_color,
  input  logic               blink_en,
  input  logic               blink_phase,
  input  logic               spr_dot,
  input  logic [IDX_W-1:0]   spr_color,
  input  logic [IDX_W-1:0]   hl_color,
  input  logic [IDX_W-1:0]   sh_color,
  input  logic               disp_en,
  input  logic               disp_pol,
  input  logic               half_en,
  input  logic               half_pol,
  input  logic               pal_we,
  input  logic [IDX_W-1:0]   pal_addr,
  input  logic [OUT_W-1:0]   pal_data,
  output logic [OUT_W-1:0]   color_out,
  output logic               disp_out,
  output logic               half_out
);

  localparam int NUM_BG = 2;

  // background layers: index 0 = row, index 1 = cell
  logic [1:0]       bg_mode_raw [NUM_BG];
  logic [IDX_W-1:0] bg_base     [NUM_BG];
  logic             bg_tl       [NUM_BG];
  logic             bg_br       [NUM_BG];
  logic             bg_vis      [NUM_BG];
  logic [IDX_W-1:0] bg_idx      [NUM_BG];

  assign bg_mode_raw[0] = row_mode;
  assign bg_base[0]     = row_color;
  assign bg_tl[0]       = row_edge_tl;
  assign bg_br[0]       = row_edge_br;
  assign bg_mode_raw[1] = cell_mode;
  assign bg_base[1]     = cell_color;
  assign bg_tl[1]       = cell_edge_tl;
  assign bg_br[1]       = cell_edge_br;

  for (genvar g = 0; g < NUM_BG; g++) begin : g_bevel
    osd_bevel_shade #(.IDX_W(IDX_W)) u_shade (
      .mode    (bg_mode_e'(bg_mode_raw[g])),
      .base    (bg_base[g]),
      .edge_tl (bg_tl[g]),
      .edge_br (bg_br[g]),
      .light   (hl_color),
      .dark    (sh_color),
      .vis     (bg_vis[g]),
      .color   (bg_idx[g])
    );
  end

  logic glyph_vis;
  assign glyph_vis = fg_dot & (~blink_en | blink_phase);

  layer_e           winner;
  logic [IDX_W-1:0] mix_idx;

  osd_layer_arbiter #(.IDX_W(IDX_W)) u_arb (
    .scr_vis   (scr_en),
    .scr_idx   (scr_color),
    .pat_vis   (pat_dot),
    .pat_idx   (pat_color),
    .row_vis   (bg_vis[0]),
    .row_idx   (bg_idx[0]),
    .cell_vis  (bg_vis[1]),
    .cell_idx  (bg_idx[1]),
    .glyph_vis (glyph_vis),
    .glyph_idx (fg_color),
    .spr_vis   (spr_dot),
    .spr_idx   (spr_color),
    .winner    (winner),
    .win_idx   (mix_idx)
  );

  logic disp_flag, half_flag;
  assign disp_flag = (winner != LY_NONE) && (winner != LY_SCREEN);
  assign half_flag = (winner == LY_ROW) || (winner == LY_CELL);

  logic [OUT_W-1:0] pal_rd;

  osd_palette_ram #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_data),
    .raddr (mix_idx),
    .rdata (pal_rd)
  );

  logic shown_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q  <= 1'b0;
      disp_out <= 1'b0;
      half_out <= 1'b0;
    end else begin
      shown_q  <= (winner != LY_NONE);
      disp_out <= disp_en & (disp_flag ~^ disp_pol);
      half_out <= half_en & (half_flag ~^ half_pol);
    end
  end

  assign color_out = shown_q ? pal_rd : '0;

  AST_SPRITE_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    spr_dot |-> (mix_idx == spr_color)); // R3

  AST_BLINK_HIDES_GLYPH: assert property (@(posedge clk) disable iff (rst)
    (blink_en && !blink_phase) |-> (winner != LY_GLYPH)); // R4

  AST_EMPTY_IS_DARK: assert property (@(posedge clk) disable iff (rst)
    (winner == LY_NONE) |=> (color_out == '0)); // R6

  AST_HALF_WITHIN_DISP: assert property (@(posedge clk) disable iff (rst)
    half_flag |-> disp_flag); // R12

  AST_DISP_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> !disp_out); // R13

  AST_HALF_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !half_en |=> !half_out); // R13

endmodule

// File: tb/osd_pixel_mixer_test.sv
module osd_pixel_mixer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       scr_en;
  logic [3:0] scr_color;
  logic       pat_dot;
  logic [3:0] pat_color;
  logic [1:0] row_mode;
  logic [3:0] row_color;
  logic       row_edge_tl, row_edge_br;
  logic [1:0] cell_mode;
  logic [3:0] cell_color;
  logic       cell_edge_tl, cell_edge_br;
  logic       fg_dot;
  logic [3:0] fg_color;
  logic       blink_en, blink_phase;
  logic       spr_dot;
  logic [3:0] spr_color;
  logic [3:0] hl_color, sh_color;
  logic       disp_en, disp_pol, half_en, half_pol;
  logic       pal_we;
  logic [3:0] pal_addr;
  logic [5:0] pal_data;
  logic [5:0] color_out;
  logic       disp_out, half_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [5:0] exp_pal [16];

  always #2.5 clk = ~clk;

  osd_pixel_mixer uut (
    .clk(clk), .rst(rst),
    .scr_en(scr_en), .scr_color(scr_color),
    .pat_dot(pat_dot), .pat_color(pat_color),
    .row_mode(row_mode), .row_color(row_color),
    .row_edge_tl(row_edge_tl), .row_edge_br(row_edge_br),
    .cell_mode(cell_mode), .cell_color(cell_color),
    .cell_edge_tl(cell_edge_tl), .cell_edge_br(cell_edge_br),
    .fg_dot(fg_dot), .fg_color(fg_color),
    .blink_en(blink_en), .blink_phase(blink_phase),
    .spr_dot(spr_dot), .spr_color(spr_color),
    .hl_color(hl_color), .sh_color(sh_color),
    .disp_en(disp_en), .disp_pol(disp_pol),
    .half_en(half_en), .half_pol(half_pol),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
    .color_out(color_out), .disp_out(disp_out), .half_out(half_out)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_layers();
    scr_en = 0; pat_dot = 0; row_mode = 0; cell_mode = 0;
    row_edge_tl = 0; row_edge_br = 0; cell_edge_tl = 0; cell_edge_br = 0;
    fg_dot = 0; blink_en = 0; blink_phase = 0; spr_dot = 0;
  endtask

  task automatic pal_write(int a, logic [5:0] d);
    pal_we = 1; pal_addr = 4'(a); pal_data = d;
    step();
    pal_we = 0;
    exp_pal[a] = d;
  endtask

  task automatic t_reset();
    rst = 1; spr_dot = 1; fg_dot = 1;
    step(); step();
    chk("R1 color", color_out, 0);
    chk("R1 disp", disp_out, 0);
    chk("R1 half", half_out, 0);
    rst = 0; clear_layers();
  endtask

  task automatic t_pal_load();
    for (int i = 0; i < 16; i++) pal_write(i, 6'((i * 13 + 5) % 64));
  endtask

  task automatic t_screen();
    clear_layers(); step();
    chk("R6 empty color", color_out, 0);
    chk("R11 empty disp", disp_out, 0);
    scr_en = 1; step();
    chk("R6 screen color", color_out, exp_pal[1]);
    chk("R11 screen no disp", disp_out, 0);
    chk("R12 screen no half", half_out, 0);
  endtask

  task automatic t_priority();
    clear_layers(); scr_en = 1;
    pat_dot = 1; step();
    chk("R5 pattern", color_out, exp_pal[2]);
    chk("R11 pattern disp", disp_out, 1);
    chk("R12 pattern half", half_out, 0);
    row_mode = 1; step();
    chk("R5 row", color_out, exp_pal[3]);
    chk("R12 row half", half_out, 1);
    cell_mode = 1; step();
    chk("R5 cell", color_out, exp_pal[4]);
    chk("R12 cell half", half_out, 1);
    fg_dot = 1; step();
    chk("R5 glyph", color_out, exp_pal[5]);
    chk("R12 glyph half", half_out, 0);
    chk("R11 glyph disp", disp_out, 1);
  endtask

  task automatic t_sprite();
    clear_layers(); scr_en = 1; pat_dot = 1; row_mode = 1; cell_mode = 3;
    cell_edge_tl = 1; fg_dot = 1; spr_dot = 1; step();
    chk("R3 sprite", color_out, exp_pal[6]);
    chk("R3 sprite half", half_out, 0);
    spr_dot = 0; step();
    chk("R3 sprite off", color_out, exp_pal[5]);
  endtask

  task automatic t_blink();
    clear_layers(); cell_mode = 1; fg_dot = 1; blink_en = 1; blink_phase = 0; step();
    chk("R4 hidden", color_out, exp_pal[4]);
    blink_phase = 1; step();
    chk("R4 shown", color_out, exp_pal[5]);
    blink_en = 0; blink_phase = 0; step();
    chk("R4 no blink", color_out, exp_pal[5]);
    clear_layers(); fg_dot = 1; blink_en = 1; step();
    chk("R4 hidden alone", color_out, 0);
    chk("R4 hidden disp", disp_out, 0);
  endtask

  task automatic t_bevel();
    clear_layers(); cell_edge_tl = 1; step();
    chk("R7 off", color_out, 0);
    cell_mode = 1; step();
    chk("R7 fill edge", color_out, exp_pal[4]);
    cell_mode = 3; step();
    chk("R8 raised tl", color_out, exp_pal[7]);
    cell_edge_tl = 0; cell_edge_br = 1; step();
    chk("R8 raised br", color_out, exp_pal[8]);
    cell_edge_tl = 1; step();
    chk("R8 raised corner", color_out, exp_pal[7]);
    cell_edge_tl = 0; cell_edge_br = 0; step();
    chk("R8 raised inner", color_out, exp_pal[4]);
    cell_mode = 2; cell_edge_tl = 1; step();
    chk("R9 sunken tl", color_out, exp_pal[8]);
    cell_edge_tl = 0; cell_edge_br = 1; step();
    chk("R9 sunken br", color_out, exp_pal[7]);
    cell_edge_tl = 1; step();
    chk("R9 sunken corner", color_out, exp_pal[8]);
    clear_layers(); row_mode = 3; row_edge_br = 1; step();
    chk("R8 row raised br", color_out, exp_pal[8]);
  endtask

  task automatic t_flags();
    clear_layers(); row_mode = 1; disp_pol = 0; step();
    chk("R13 disp inverted", disp_out, 0);
    chk("R13 half high", half_out, 1);
    half_pol = 0; step();
    chk("R13 half inverted", half_out, 0);
    clear_layers(); step();
    chk("R13 disp inverted idle", disp_out, 1);
    chk("R13 half inverted idle", half_out, 1);
    disp_en = 0; half_en = 0; step();
    chk("R13 disp off", disp_out, 0);
    chk("R13 half off", half_out, 0);
    disp_en = 1; half_en = 1; disp_pol = 1; half_pol = 1;
  endtask

  task automatic t_latency();
    clear_layers(); fg_dot = 1; step();
    chk("R2 first", color_out, exp_pal[5]);
    fg_dot = 0; spr_dot = 1; #1;
    chk("R2 held", color_out, exp_pal[5]);
    step();
    chk("R2 next", color_out, exp_pal[6]);
  endtask

  task automatic t_pal_rewrite();
    clear_layers();
    pal_write(5, 6'h3F);
    fg_dot = 1; step();
    chk("R10 rewritten", color_out, 6'h3F);
    fg_dot = 0; spr_dot = 1; step();
    chk("R10 other entry", color_out, exp_pal[6]);
  endtask

  initial begin
    scr_color = 1; pat_color = 2; row_color = 3; cell_color = 4;
    fg_color = 5; spr_color = 6; hl_color = 7; sh_color = 8;
    disp_en = 1; disp_pol = 1; half_en = 1; half_pol = 1;
    pal_we = 0; pal_addr = 0; pal_data = 0;
    clear_layers();
    rst = 1;
    #1;
    t_reset();
    t_pal_load();
    t_screen();
    t_priority();
    t_sprite();
    t_blink();
    t_bevel();
    t_flags();
    t_latency();
    t_pal_rewrite();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule